// File: doc/BRIEF.md
# Dual-Cache Snooping Coherence Controller

This block puts two small write-back data caches, one for each processor, on a shared snooping bus. The bus sits in front of a word-addressed main memory that is held in registers. Each cache is direct-mapped, with four lines. A line carries a valid flag, a dirty flag, a tag and four data words. Each processor issues single-word reads and writes.

The bus carries one transaction per cycle. The cache that is not granted observes that transaction in the same cycle and keeps its own copy coherent. A runtime control pin selects how a write affects the other copy. In one policy the other copy is discarded. In the other policy the new word is copied into it.

A miss is filled from the peer cache when the peer holds the line dirty, and main memory is written with that line in the same cycle. Otherwise the miss is filled from main memory. Because coherence is tracked per line, writes to neighbouring words cause false-sharing misses. These misses are counted apart from the other misses.

The request side of each processor is a valid/ready stream. A request is held until ready is seen, and ready rises only in the cycle the bus takes that request. The response side has no back-pressure. The response is a one-cycle pulse that the processor must accept when it arrives.

Top module: `snoop_pair`

## Requirements
- R1: At most one request is taken per cycle, and processor 0 wins when both request. The req_ready of a processor is high only in the cycle its request is taken. Exactly one cycle later, its rsp_valid is high for one cycle.
- R2: A word address splits into tag in bits [5:4], line index in bits [3:2] and word offset in bits [1:0]. After reset both caches are empty, both counters read 0, and memory word k holds k (for example, address 45 reads 45).
- R3: A read returns the last value written to that address by either processor, under either policy. Example: P1 reads 7 (value 7), P1 writes 5, P0 reads 7 (gets 5), P1 writes 3, P0 reads 7 and gets 3.
- R4: With policy = 0 (invalidate), a write discards the peer's matching line. The peer's next access to that line misses (rsp_hit = 0).
- R5: With policy = 1 (update), a write copies the new word into the peer's matching line. The peer's next read of that word hits and returns the new value.
- R6: A miss while the peer holds the line dirty takes the peer's data and writes that line to memory. After both caches later evict the line, a read from memory returns the supplied value.
- R7: With policy = 0, writes by the two processors to different words of one line (addresses 0 and 1) invalidate each other's copy and cause coherence misses.
- R8: Replacing a dirty line writes it back to memory, so a later miss on the old address returns the written data.
- R9: miss_count increments by one on every miss. coh_count increments only on a miss to a line whose tag still matches and that was discarded by a peer write. Both counters saturate at their maximum value.
- R10: rsp_hit is 1 when the access hit the requesting cache and 0 when it missed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 1 | 0 = discard peer copy on write, 1 = copy word to peer |
| p0_req_valid | input | 1 | Processor 0 request present |
| p0_req_ready | output | 1 | Processor 0 request taken this cycle |
| p0_req_write | input | 1 | Processor 0: 1 = write, 0 = read |
| p0_req_addr | input | 6 | Processor 0 word address |
| p0_req_wdata | input | 8 | Processor 0 write data |
| p0_rsp_valid | output | 1 | Processor 0 response pulse |
| p0_rsp_data | output | 8 | Processor 0 data of the addressed word |
| p0_rsp_hit | output | 1 | Processor 0 access hit |
| p0_miss_count | output | 8 | Processor 0 saturating miss count |
| p0_coh_count | output | 8 | Processor 0 saturating coherence-miss count |
| p1_req_valid | input | 1 | Processor 1 request present |
| p1_req_ready | output | 1 | Processor 1 request taken this cycle |
| p1_req_write | input | 1 | Processor 1: 1 = write, 0 = read |
| p1_req_addr | input | 6 | Processor 1 word address |
| p1_req_wdata | input | 8 | Processor 1 write data |
| p1_rsp_valid | output | 1 | Processor 1 response pulse |
| p1_rsp_data | output | 8 | Processor 1 data of the addressed word |
| p1_rsp_hit | output | 1 | Processor 1 access hit |
| p1_miss_count | output | 8 | Processor 1 saturating miss count |
| p1_coh_count | output | 8 | Processor 1 saturating coherence-miss count |

## Verification
The assertions assume that a processor keeps its request valid and stable until ready, and that policy changes only between transactions. Under those assumptions they require that a line is never held dirty by both caches at once. The stimulus meets these assumptions in three ways. Each scenario drives requests from a single task that holds valid until ready. Policy is set only while reset is asserted. Both processors are raised in the same cycle only in the dedicated arbitration scenario.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic {
    POL_INVALIDATE = 1'b0,
    POL_UPDATE     = 1'b1
  } policy_e;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic snooped;   // discarded by a peer write, tag still kept
  } line_state_t;
endpackage

// File: rtl/snoop_arb.sv
module snoop_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  output logic [1:0] gnt
);
  assign gnt[0] = req[0];
  assign gnt[1] = req[1] & ~req[0];

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R1
  AST_TIE_TO_P0: assert property (@(posedge clk) disable iff (!rst_n)
    (req == 2'b11) |-> (gnt == 2'b01)); // R1
endmodule

// File: rtl/snoop_cache.sv
module snoop_cache
  import snoop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TAG_W  = 2,
  parameter int IDX_W  = 2,
  parameter int WORDS  = 4,
  parameter int CNT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              look_idx,
  output line_state_t                   rd_state,
  output logic [TAG_W-1:0]              rd_tag,
  output logic [WORDS-1:0][DATA_W-1:0]  rd_data,
  input  logic                          wr_en,
  input  line_state_t                   wr_state,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [WORDS-1:0][DATA_W-1:0]  wr_data,
  input  logic                          miss_inc,
  input  logic                          coh_inc,
  output logic [CNT_W-1:0]              miss_cnt,
  output logic [CNT_W-1:0]              coh_cnt
);
  localparam int LINES = 1 << IDX_W;

  line_state_t                  state_q [LINES];
  logic [TAG_W-1:0]             tag_q   [LINES];
  logic [WORDS-1:0][DATA_W-1:0] data_q  [LINES];

  assign rd_state = state_q[look_idx];
  assign rd_tag   = tag_q[look_idx];
  assign rd_data  = data_q[look_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        state_q[i] <= '0;
        tag_q[i]   <= '0;
        data_q[i]  <= '0;
      end
      miss_cnt <= '0;
      coh_cnt  <= '0;
    end else begin
      if (wr_en) begin
        state_q[look_idx] <= wr_state;
        tag_q[look_idx]   <= wr_tag;
        data_q[look_idx]  <= wr_data;
      end
      if (miss_inc && miss_cnt != '1) miss_cnt <= miss_cnt + 1'b1;
      if (coh_inc && coh_cnt != '1)   coh_cnt  <= coh_cnt + 1'b1;
    end
  end

  AST_COH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    coh_cnt <= miss_cnt); // R9
endmodule

// File: rtl/snoop_dram.sv
module snoop_dram #(
  parameter int DATA_W = 8,
  parameter int LA_W   = 4,
  parameter int WORDS  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LA_W-1:0]               rd_line,
  output logic [WORDS-1:0][DATA_W-1:0]  rd_data,
  input  logic                          wa_en,
  input  logic [LA_W-1:0]               wa_line,
  input  logic [WORDS-1:0][DATA_W-1:0]  wa_data,
  input  logic                          wb_en,
  input  logic [LA_W-1:0]               wb_line,
  input  logic [WORDS-1:0][DATA_W-1:0]  wb_data
);
  localparam int NLINE = 1 << LA_W;

  logic [WORDS-1:0][DATA_W-1:0] mem_q [NLINE];

  assign rd_data = mem_q[rd_line];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < NLINE; j++)
        for (int w = 0; w < WORDS; w++)
          mem_q[j][w] <= DATA_W'(j * WORDS + w);
    end else begin
      if (wa_en) mem_q[wa_line] <= wa_data;
      if (wb_en) mem_q[wb_line] <= wb_data;
    end
  end

  AST_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wb_en) |-> (wa_line != wb_line)); // R8
endmodule

// File: rtl/snoop_pair.sv
module snoop_pair
  import snoop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TAG_W  = 2,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2,
  parameter int CNT_W  = 8,
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              policy,
  input  logic              p0_req_valid,
  output logic              p0_req_ready,
  input  logic              p0_req_write,
  input  logic [ADDR_W-1:0] p0_req_addr,
  input  logic [DATA_W-1:0] p0_req_wdata,
  output logic              p0_rsp_valid,
  output logic [DATA_W-1:0] p0_rsp_data,
  output logic              p0_rsp_hit,
  output logic [CNT_W-1:0]  p0_miss_count,
  output logic [CNT_W-1:0]  p0_coh_count,
  input  logic              p1_req_valid,
  output logic              p1_req_ready,
  input  logic              p1_req_write,
  input  logic [ADDR_W-1:0] p1_req_addr,
  input  logic [DATA_W-1:0] p1_req_wdata,
  output logic              p1_rsp_valid,
  output logic [DATA_W-1:0] p1_rsp_data,
  output logic              p1_rsp_hit,
  output logic [CNT_W-1:0]  p1_miss_count,
  output logic [CNT_W-1:0]  p1_coh_count
);
  localparam int WORDS = 1 << OFF_W;
  localparam int LA_W  = TAG_W + IDX_W;
  typedef logic [WORDS-1:0][DATA_W-1:0] line_t;

  logic [1:0] gnt;
  snoop_arb u_arb (.clk(clk), .rst_n(rst_n), .req({p1_req_valid, p0_req_valid}), .gnt(gnt));
  assign p0_req_ready = gnt[0];
  assign p1_req_ready = gnt[1];

  // granted request
  logic              act, sel, b_write;
  logic [ADDR_W-1:0] b_addr;
  logic [DATA_W-1:0] b_wdata;
  assign act     = |gnt;
  assign sel     = gnt[1];
  assign b_write = sel ? p1_req_write : p0_req_write;
  assign b_addr  = sel ? p1_req_addr  : p0_req_addr;
  assign b_wdata = sel ? p1_req_wdata : p0_req_wdata;

  logic [TAG_W-1:0] b_tag;
  logic [IDX_W-1:0] b_idx;
  logic [OFF_W-1:0] b_off;
  assign b_tag = b_addr[ADDR_W-1 -: TAG_W];
  assign b_idx = b_addr[OFF_W +: IDX_W];
  assign b_off = b_addr[OFF_W-1:0];

  line_state_t      c_state [2];
  logic [TAG_W-1:0] c_tag   [2];
  line_t            c_data  [2];
  logic [1:0]       w_en, m_inc, h_inc;
  line_state_t      w_state [2];
  logic [TAG_W-1:0] w_tag   [2];
  line_t            w_data  [2];
  logic [CNT_W-1:0] m_cnt   [2];
  logic [CNT_W-1:0] h_cnt   [2];

  for (genvar i = 0; i < 2; i++) begin : g_cache
    snoop_cache #(.DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .WORDS(WORDS), .CNT_W(CNT_W)) u_cache (
      .clk(clk), .rst_n(rst_n), .look_idx(b_idx),
      .rd_state(c_state[i]), .rd_tag(c_tag[i]), .rd_data(c_data[i]),
      .wr_en(w_en[i]), .wr_state(w_state[i]), .wr_tag(w_tag[i]), .wr_data(w_data[i]),
      .miss_inc(m_inc[i]), .coh_inc(h_inc[i]), .miss_cnt(m_cnt[i]), .coh_cnt(h_cnt[i]));
  end

  line_t           mem_line, own_line;
  logic            own_hit, oth_match, miss, victim_wb, supply, coh_miss;
  logic            wa_en, wb_en;
  logic [LA_W-1:0] wa_line;
  line_state_t     own_st, oth_st;
  policy_e         pol;
  assign pol = policy_e'(policy);

  snoop_dram #(.DATA_W(DATA_W), .LA_W(LA_W), .WORDS(WORDS)) u_dram (
    .clk(clk), .rst_n(rst_n), .rd_line({b_tag, b_idx}), .rd_data(mem_line),
    .wa_en(wa_en), .wa_line(wa_line), .wa_data(c_data[sel]),
    .wb_en(wb_en), .wb_line({b_tag, b_idx}), .wb_data(c_data[~sel]));

  always_comb begin
    own_st    = c_state[sel];
    oth_st    = c_state[~sel];
    own_hit   = own_st.valid && c_tag[sel] == b_tag;
    oth_match = oth_st.valid && c_tag[~sel] == b_tag;
    miss      = act && !own_hit;
    coh_miss  = miss && !own_st.valid && own_st.snooped && c_tag[sel] == b_tag;
    victim_wb = miss && own_st.valid && own_st.dirty;
    supply    = miss && oth_match && oth_st.dirty;
    wa_en     = victim_wb;
    wa_line   = {c_tag[sel], b_idx};
    wb_en     = supply;

    own_line  = own_hit ? c_data[sel] : (supply ? c_data[~sel] : mem_line);
    if (b_write) own_line[b_off] = b_wdata;

    for (int i = 0; i < 2; i++) begin
      w_en[i]    = 1'b0;
      w_state[i] = c_state[i];
      w_tag[i]   = c_tag[i];
      w_data[i]  = c_data[i];
    end
    m_inc = '0;
    h_inc = '0;

    if (act) begin
      w_en[sel]          = 1'b1;
      w_tag[sel]         = b_tag;
      w_data[sel]        = own_line;
      w_state[sel].valid = 1'b1;
      w_state[sel].dirty = b_write || (own_hit && own_st.dirty);
      w_state[sel].snooped = 1'b0;
      m_inc[sel] = miss;
      h_inc[sel] = coh_miss;
      if (b_write && oth_match) begin
        w_en[~sel] = 1'b1;
        w_state[~sel].dirty = 1'b0;
        if (pol == POL_INVALIDATE) begin
          w_state[~sel].valid   = 1'b0;
          w_state[~sel].snooped = 1'b1;
        end else begin
          w_data[~sel][b_off] = b_wdata;
        end
      end else if (supply) begin
        w_en[~sel] = 1'b1;
        w_state[~sel].dirty = 1'b0;
      end
    end
  end

  // responses
  logic [1:0]        rv_q, rh_q;
  logic [DATA_W-1:0] rd_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q <= '0;
      rh_q <= '0;
      rd_q <= '0;
    end else begin
      rv_q <= gnt;
      if (act) begin
        rh_q[sel] <= own_hit;
        rd_q      <= own_line[b_off];
      end
    end
  end

  assign p0_rsp_valid  = rv_q[0];
  assign p1_rsp_valid  = rv_q[1];
  assign p0_rsp_hit    = rh_q[0];
  assign p1_rsp_hit    = rh_q[1];
  assign p0_rsp_data   = rd_q;
  assign p1_rsp_data   = rd_q;
  assign p0_miss_count = m_cnt[0];
  assign p1_miss_count = m_cnt[1];
  assign p0_coh_count  = h_cnt[0];
  assign p1_coh_count  = h_cnt[1];

  AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[0] |=> p0_rsp_valid); // R1
  AST_RSP_AFTER_GRANT1: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[1] |=> p1_rsp_valid); // R1
  AST_SINGLE_DIRTY_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_state[0].valid && c_state[0].dirty && c_state[1].valid && c_state[1].dirty
      && c_tag[0] == c_tag[1])); // R3
  AST_UPDATE_KEEPS_PEER: assert property (@(posedge clk) disable iff (!rst_n)
    (act && b_write && oth_match && pol == POL_UPDATE) |=> c_state[~$past(sel)].valid); // R5
endmodule

// File: tb/snoop_pair_bench.sv
`timescale 1ns/1ps
module snoop_pair_bench;
  logic clk = 1'b0, rst_n = 1'b0, policy = 1'b0;
  logic p0_req_valid = 0, p0_req_write = 0, p1_req_valid = 0, p1_req_write = 0;
  logic [5:0] p0_req_addr = 0, p1_req_addr = 0;
  logic [7:0] p0_req_wdata = 0, p1_req_wdata = 0;
  logic p0_req_ready, p0_rsp_valid, p0_rsp_hit, p1_req_ready, p1_rsp_valid, p1_rsp_hit;
  logic [7:0] p0_rsp_data, p1_rsp_data, p0_miss_count, p0_coh_count, p1_miss_count, p1_coh_count;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  snoop_pair u_snoop_pair (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic pol);
    @(negedge clk);
    rst_n = 0; policy = pol; p0_req_valid = 0; p1_req_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic acc(input int p, input bit wr, input int addr, input int wd,
                     output int rd, output int hit);
    @(negedge clk);
    if (p == 0) begin
      p0_req_valid = 1; p0_req_write = wr; p0_req_addr = 6'(addr); p0_req_wdata = 8'(wd);
    end else begin
      p1_req_valid = 1; p1_req_write = wr; p1_req_addr = 6'(addr); p1_req_wdata = 8'(wd);
    end
    #1;
    while (!(p == 0 ? p0_req_ready : p1_req_ready)) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    if (p == 0) p0_req_valid = 0; else p1_req_valid = 0;
    chk("R1 rsp_valid", p == 0 ? p0_rsp_valid : p1_rsp_valid, 1);
    rd  = p == 0 ? p0_rsp_data : p1_rsp_data;
    hit = p == 0 ? p0_rsp_hit  : p1_rsp_hit;
  endtask

  task automatic t_reset;
    int d, h;
    do_reset(0);
    chk("R2 p0 miss_count", p0_miss_count, 0);
    chk("R2 p1 coh_count", p1_coh_count, 0);
    chk("R1 idle rsp_valid", p0_rsp_valid, 0);
    acc(0, 0, 45, 0, d, h);
    chk("R2 mem word 45", d, 45);
    chk("R10 cold read misses", h, 0);
  endtask

  task automatic t_invalidate;
    int d, h;
    do_reset(0);
    acc(1, 0, 7, 0, d, h);  chk("R3 first read", d, 7);
    acc(1, 1, 7, 5, d, h);  chk("R10 write hit", h, 1);
    acc(0, 0, 7, 0, d, h);  chk("R6 dirty supply", d, 5);
    chk("R9 cold miss not coherence", p0_coh_count, 0);
    acc(1, 1, 7, 3, d, h);
    acc(0, 0, 7, 0, d, h);  chk("R3 latest value", d, 3);
    chk("R4 peer copy discarded", h, 0);
    chk("R9 coherence miss", p0_coh_count, 1);
    acc(0, 0, 23, 0, d, h); chk("R2 conflict line read", d, 23);
    acc(1, 0, 23, 0, d, h);
    acc(0, 0, 7, 0, d, h);  chk("R6 memory got supplied line", d, 3);
    chk("R9 miss total", p0_miss_count, 4);
    chk("R9 coherence unchanged", p0_coh_count, 1);
  endtask

  task automatic t_update;
    int d, h;
    do_reset(1);
    acc(1, 0, 7, 0, d, h);
    acc(1, 1, 7, 5, d, h);
    acc(0, 0, 7, 0, d, h);  chk("R3 update supply", d, 5);
    acc(1, 1, 7, 3, d, h);
    acc(0, 0, 7, 0, d, h);  chk("R5 peer refreshed value", d, 3);
    chk("R5 peer read hits", h, 1);
    chk("R9 no coherence miss", p0_coh_count, 0);
    acc(0, 1, 7, 9, d, h);
    acc(1, 0, 7, 0, d, h);  chk("R5 reverse refresh", d, 9);
    chk("R5 reverse hit", h, 1);
  endtask

  task automatic t_false_share;
    int d, h;
    do_reset(0);
    acc(1, 0, 0, 0, d, h);
    acc(0, 0, 1, 0, d, h);
    acc(1, 1, 0, 5, d, h);
    acc(0, 1, 1, 3, d, h);  chk("R7 neighbour write misses", h, 0);
    chk("R7 p0 coherence count", p0_coh_count, 1);
    acc(1, 0, 0, 0, d, h);  chk("R7 p1 keeps its word", d, 5);
    chk("R7 p1 coherence count", p1_coh_count, 1);
    acc(0, 0, 1, 0, d, h);  chk("R7 p0 word kept", d, 3);
    chk("R10 p0 still valid", h, 1);
  endtask

  task automatic t_evict;
    int d, h;
    do_reset(0);
    acc(0, 1, 2, 170, d, h);
    acc(0, 0, 18, 0, d, h); chk("R8 conflicting read", d, 18);
    acc(0, 0, 2, 0, d, h);  chk("R8 written back", d, 170);
    acc(1, 0, 2, 0, d, h);  chk("R8 peer sees memory", d, 170);
  endtask

  task automatic t_arb;
    do_reset(0);
    @(negedge clk);
    p0_req_valid = 1; p0_req_addr = 6'd4; p0_req_write = 0;
    p1_req_valid = 1; p1_req_addr = 6'd8; p1_req_write = 0;
    #1;
    chk("R1 p0 wins tie", p0_req_ready, 1);
    chk("R1 p1 waits", p1_req_ready, 0);
    @(negedge clk);
    p0_req_valid = 0;
    chk("R1 p0 response", p0_rsp_valid, 1);
    chk("R1 p0 data", p0_rsp_data, 4);
    #1;
    chk("R1 p1 taken next", p1_req_ready, 1);
    @(negedge clk);
    p1_req_valid = 0;
    chk("R1 p0 single pulse", p0_rsp_valid, 0);
    chk("R1 p1 response", p1_rsp_valid, 1);
    chk("R1 p1 data", p1_rsp_data, 8);
  endtask

  task automatic t_saturate;
    int d, h;
    do_reset(0);
    for (int k = 0; k < 260; k++) acc(0, 0, (k % 2) * 16, 0, d, h);
    chk("R9 miss count saturates", p0_miss_count, 255);
  endtask

  initial begin
    t_reset();
    t_invalidate();
    t_update();
    t_false_share();
    t_evict();
    t_arb();
    t_saturate();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule